// File: doc/BRIEF.md
# Secondary Core Power-Up Sequencer

This block is a hardware state machine that wakes a powered-down secondary processor core. Software places the core's entry address on an input and pulses a start line. The machine then walks through the whole bring-up on its own: it latches the entry address, holds both core resets, clears the L1 reset-disable flag and the debug power-up flag, and lowers an 8-bit power clamp one bit at a time. It then waits out long settle intervals, opens the power-off gate, releases the resets and finally raises debug power-up together with a done flag.

Each wait is a parameter counted in clock cycles. The two settle intervals default to 10 ms and 1 ms derived from `CLK_HZ`, and every clamp value is held for `STEP_HOLD` cycles. Once the core is up, a power-down pulse runs the steps backwards and leaves the core clamped, gated and in reset, ready for another start.

Top module: `core_wake_seq`

## Requirements
- R1: While `rst_n` is low and after its release, outputs are: `boot_addr_o`=0, `rst_ctl_o`=2'b00, `l1_rst_dis_o`=1, `dbg_pwrup_o`=0, `clamp_o`=8'hFF, `pwr_gate_o`=1, `busy_o`=0, `done_o`=0.
- R2: A `start_i` sampled high while `busy_o`=0 and `done_o`=0 is accepted at that clock edge: `boot_addr_o` takes `entry_addr_i` and `busy_o` rises on the same edge.
- R3: Counting the accepting edge as offset 0, `rst_ctl_o` becomes 2'b00 at offset 1, `l1_rst_dis_o` becomes 0 at offset 2 and `dbg_pwrup_o` becomes 0 at offset 3.
- R4: From offset 4, `clamp_o` takes the values 8'hFF >> n for n = 0..8 (FF, 7F, 3F, 1F, 0F, 07, 03, 01, 00). Value n appears at offset 4 + n*STEP_HOLD, and successive values differ in exactly one bit.
- R5: `pwr_gate_o` falls LONG_CYC cycles after `clamp_o` reaches 0.
- R6: SHORT_CYC cycles after the gate opens, `rst_ctl_o` becomes 2'b11. One cycle later `dbg_pwrup_o` rises, `done_o` rises and `busy_o` falls, all on that same edge.
- R7: `start_i` or `pdown_i` pulses sampled while `busy_o`=1 are ignored, including at the edge where the sequence finishes. `boot_addr_o` and the step timing are unaffected.
- R8: While `done_o`=1 and the block is idle, `start_i` is ignored. `done_o` stays high until a power-down is accepted.
- R9: A `pdown_i` sampled high while `done_o`=1 and `busy_o`=0 is accepted. At that edge (offset 0) `done_o` falls and `busy_o` rises. `dbg_pwrup_o` falls at offset 1, `rst_ctl_o` becomes 2'b00 at offset 2 and `pwr_gate_o` rises at offset 3. `clamp_o` then climbs 01, 03, ... FF, with the k-th value (k = 1..8) at offset 4 + (k-1)*STEP_HOLD. `busy_o` falls with the last value, and `l1_rst_dis_o` stays 0.
- R10: A `pdown_i` pulse while `done_o`=0 and the block is idle has no effect on any output.
- R11: When `start_i` and `pdown_i` are both high at an idle edge with `done_o`=1, the power-down runs and `boot_addr_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Power-up request pulse |
| pdown_i | input | 1 | Power-down request pulse |
| entry_addr_i | input | ADDR_W | Entry address for the secondary core |
| boot_addr_o | output | ADDR_W | Latched boot address |
| rst_ctl_o | output | 2 | Core reset controls, active low (bit0 core, bit1 power-on) |
| l1_rst_dis_o | output | 1 | L1 reset-disable flag |
| dbg_pwrup_o | output | 1 | Debug power-up flag |
| clamp_o | output | CLAMP_W | Graded power-clamp bus |
| pwr_gate_o | output | 1 | Power-off gate, 1 = gated |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Core is powered up |

## Verification
The acceptance of a request can coincide with the end of a sequence. The bench drives a start pulse timed to the very edge where debug power-up rises and busy falls, and expects it to be dropped, with no new boot address and no second run. A start and a power-down can also arrive in the same idle cycle while done is high. The bench presents both together and judges the result against the power-down timeline, with the boot address unchanged. Random extra pulses during both sequences are checked against a timeline the bench computes from the step offsets.

// File: rtl/core_wake_pkg.sv
package core_wake_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST0,
    ST_L1,
    ST_DBG0,
    ST_CLMP0,
    ST_CLMP,
    ST_GATE,
    ST_RST1,
    ST_DBG1,
    ST_DDBG,
    ST_DRST,
    ST_DGATE,
    ST_DCLMP
  } step_e;

  // a wait of d cycles between two actions loads d-1 into the counter
  function automatic int unsigned wait_load(input int unsigned d);
    return (d == 0) ? 0 : d - 1;
  endfunction

  function automatic int unsigned at_least_one(input int unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/cws_delay.sv
module cws_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // R5: an unloaded wait moves down by exactly one per cycle
  a_r5_wait_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/cws_clamp.sv
module cws_clamp #(
  parameter int W     = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [W-1:0]     clamp_o
);

  logic [IDX_W-1:0] idx_q;

  function automatic logic [W-1:0] thermo(input logic [IDX_W-1:0] n);
    return {W{1'b1}} >> n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_q <= '0;
    else if (first_i) idx_q <= '0;
    else if (inc_i)   idx_q <= idx_q + 1'b1;
    else if (dec_i)   idx_q <= idx_q - 1'b1;
  end

  assign idx_o   = idx_q;
  assign clamp_o = thermo(idx_q);

  // R4: the clamp never changes by more than one bit per edge
  a_r4_single_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clamp_o) |-> $countones(clamp_o ^ $past(clamp_o)) == 1);

endmodule

// File: rtl/core_wake_seq.sv
module core_wake_seq
  import core_wake_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CLAMP_W    = 8,
  parameter int CLK_HZ     = 100_000_000,
  parameter int LONG_CYC   = CLK_HZ / 100,
  parameter int SHORT_CYC  = CLK_HZ / 1000,
  parameter int STEP_HOLD  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               pdown_i,
  input  logic [ADDR_W-1:0]  entry_addr_i,
  output logic [ADDR_W-1:0]  boot_addr_o,
  output logic [1:0]         rst_ctl_o,
  output logic               l1_rst_dis_o,
  output logic               dbg_pwrup_o,
  output logic [CLAMP_W-1:0] clamp_o,
  output logic               pwr_gate_o,
  output logic               busy_o,
  output logic               done_o
);

  localparam int LONG_E  = at_least_one(LONG_CYC);
  localparam int SHORT_E = at_least_one(SHORT_CYC);
  localparam int HOLD_E  = at_least_one(STEP_HOLD);
  localparam int MAX_A   = (LONG_E > SHORT_E) ? LONG_E : SHORT_E;
  localparam int MAX_D   = (MAX_A > HOLD_E) ? MAX_A : HOLD_E;
  localparam int CNT_W   = (MAX_D > 1) ? $clog2(MAX_D) : 1;
  localparam int IDX_W   = $clog2(CLAMP_W + 1);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(wait_load(LONG_E));
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(wait_load(SHORT_E));
  localparam logic [CNT_W-1:0] HOLD_V  = CNT_W'(wait_load(HOLD_E));

  step_e              step_q;
  logic               busy_q, done_q, l1_q, dbg_q, gate_q;
  logic [1:0]         rst_q;
  logic [ADDR_W-1:0]  boot_q;
  logic [IDX_W-1:0]   idx;

  // named events
  logic expired, fire, up_acc, dn_acc, clamp_bottom, clamp_top;
  logic ld;
  logic [CNT_W-1:0] ld_val;
  logic c_first, c_inc, c_dec;

  assign fire         = busy_q && expired;
  assign up_acc       = !busy_q && !done_q && start_i;
  assign dn_acc       = !busy_q && done_q && pdown_i;
  assign clamp_bottom = (idx == IDX_W'(CLAMP_W - 1));
  assign clamp_top    = (idx == IDX_W'(1));

  always_comb begin
    ld      = up_acc || dn_acc;
    ld_val  = '0;
    c_first = 1'b0;
    c_inc   = 1'b0;
    c_dec   = 1'b0;
    if (fire) begin
      unique case (step_q)
        ST_CLMP0: begin c_first = 1'b1; ld = 1'b1; ld_val = HOLD_V; end
        ST_CLMP:  begin
          c_inc = 1'b1; ld = 1'b1;
          ld_val = clamp_bottom ? LONG_V : HOLD_V;
        end
        ST_GATE:  begin ld = 1'b1; ld_val = SHORT_V; end
        ST_DCLMP: begin c_dec = 1'b1; ld = 1'b1; ld_val = HOLD_V; end
        ST_DBG1, ST_IDLE: ld = ld;
        default:  begin ld = 1'b1; ld_val = '0; end
      endcase
    end
  end

  cws_delay #(.CNT_W(CNT_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load_i(ld), .val_i(ld_val), .expired_o(expired)
  );

  cws_clamp #(.W(CLAMP_W), .IDX_W(IDX_W)) u_clamp (
    .clk(clk), .rst_n(rst_n), .first_i(c_first), .inc_i(c_inc), .dec_i(c_dec),
    .idx_o(idx), .clamp_o(clamp_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      boot_q <= '0;
      rst_q  <= 2'b00;
      l1_q   <= 1'b1;
      dbg_q  <= 1'b0;
      gate_q <= 1'b1;
    end else if (up_acc) begin
      boot_q <= entry_addr_i;
      busy_q <= 1'b1;
      step_q <= ST_RST0;
    end else if (dn_acc) begin
      done_q <= 1'b0;
      busy_q <= 1'b1;
      step_q <= ST_DDBG;
    end else if (fire) begin
      unique case (step_q)
        ST_RST0:  begin rst_q <= 2'b00; step_q <= ST_L1;    end
        ST_L1:    begin l1_q  <= 1'b0;  step_q <= ST_DBG0;  end
        ST_DBG0:  begin dbg_q <= 1'b0;  step_q <= ST_CLMP0; end
        ST_CLMP0: step_q <= ST_CLMP;
        ST_CLMP:  if (clamp_bottom) step_q <= ST_GATE;
        ST_GATE:  begin gate_q <= 1'b0; step_q <= ST_RST1; end
        ST_RST1:  begin rst_q <= 2'b11; step_q <= ST_DBG1; end
        ST_DBG1:  begin
          dbg_q  <= 1'b1;
          done_q <= 1'b1;
          busy_q <= 1'b0;
          step_q <= ST_IDLE;
        end
        ST_DDBG:  begin dbg_q  <= 1'b0;  step_q <= ST_DRST;  end
        ST_DRST:  begin rst_q  <= 2'b00; step_q <= ST_DGATE; end
        ST_DGATE: begin gate_q <= 1'b1;  step_q <= ST_DCLMP; end
        ST_DCLMP: if (clamp_top) begin busy_q <= 1'b0; step_q <= ST_IDLE; end
        default:  step_q <= ST_IDLE;
      endcase
    end
  end

  assign boot_addr_o  = boot_q;
  assign rst_ctl_o    = rst_q;
  assign l1_rst_dis_o = l1_q;
  assign dbg_pwrup_o  = dbg_q;
  assign pwr_gate_o   = gate_q;
  assign busy_o       = busy_q;
  assign done_o       = done_q;

  // R2: the boot address moves only on an accepted start
  a_r2_boot_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(boot_addr_o) |-> $past(up_acc));

  // R7: requests during a run leave the boot address alone
  a_r7_boot_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(boot_addr_o));

  // R5: the gate opens only with the clamp fully released and resets held
  a_r5_gate_after_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_gate_o) |-> (clamp_o == '0 && rst_ctl_o == 2'b00));

  // R6: debug power-up rises only after full release, with done
  a_r6_dbg_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_pwrup_o) |-> (rst_ctl_o == 2'b11 && !pwr_gate_o && clamp_o == '0 && done_o));

  // R6: busy and done are never high together
  a_r6_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));

  // R9: gating returns only with resets asserted and debug low
  a_r9_gate_closes_safe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_gate_o) |-> (rst_ctl_o == 2'b00 && !dbg_pwrup_o));

  // R10: a power-down with nothing powered is dropped
  a_r10_pdown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o && pdown_i && !start_i) |=> !busy_o);

endmodule

// File: tb/sim_core_wake_seq.sv
module sim_core_wake_seq;

  localparam int AW     = 32;
  localparam int CW     = 8;
  localparam int LONGC  = 40;
  localparam int SHORTC = 4;
  localparam int HOLD   = 2;
  // timeline offsets of the power-up run, relative to the accepting edge
  localparam int T_GATE = 4 + 8 * HOLD + LONGC;
  localparam int T_RST1 = T_GATE + SHORTC;
  localparam int T_DBG1 = T_RST1 + 1;
  // power-down: busy ends with the last clamp step
  localparam int T_DEND = 4 + 7 * HOLD;

  logic clk = 1'b0;
  logic rst_n, start, pdown;
  logic [AW-1:0] entry;
  logic [AW-1:0] boot;
  logic [1:0] rstc;
  logic l1, dbg, gate, busy, done;
  logic [CW-1:0] clamp;

  int n_chk = 0;
  int n_bad = 0;

  // state the bench expects while idle
  logic [AW-1:0] p_boot;
  logic [1:0]    p_rst;
  logic          p_l1, p_dbg, p_gate, p_done;
  logic [CW-1:0] p_clamp;

  always #5 clk = ~clk;

  core_wake_seq #(
    .ADDR_W(AW), .CLAMP_W(CW), .CLK_HZ(4000),
    .LONG_CYC(LONGC), .SHORT_CYC(SHORTC), .STEP_HOLD(HOLD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .pdown_i(pdown),
    .entry_addr_i(entry), .boot_addr_o(boot), .rst_ctl_o(rstc),
    .l1_rst_dis_o(l1), .dbg_pwrup_o(dbg), .clamp_o(clamp),
    .pwr_gate_o(gate), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [CW-1:0] up_clamp(input int k);
    int n;
    if (k < 4) return p_clamp;
    n = (k - 4) / HOLD;
    if (n > 8) n = 8;
    return 8'hFF >> n;
  endfunction

  function automatic logic [CW-1:0] dn_clamp(input int k);
    int m;
    if (k < 4) return 8'h00;
    m = (k - 4) / HOLD + 1;
    if (m > 8) m = 8;
    return 8'hFF >> (8 - m);
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " boot"},  boot,  p_boot);
    chk({tag, " rst"},   rstc,  p_rst);
    chk({tag, " l1"},    l1,    p_l1);
    chk({tag, " dbg"},   dbg,   p_dbg);
    chk({tag, " clamp"}, clamp, p_clamp);
    chk({tag, " gate"},  gate,  p_gate);
    chk({tag, " busy"},  busy,  1'b0);
    chk({tag, " done"},  done,  p_done);
  endtask

  // enters and leaves at a falling edge
  task automatic run_up(input logic [AW-1:0] addr, input bit hit_last);
    bit injected = 0;
    start = 1'b1; pdown = 1'b0; entry = addr;
    @(posedge clk);
    for (int k = 0; k <= T_DBG1 + 2; k++) begin
      @(negedge clk);
      chk(injected ? "R7 boot" : "R2 boot", boot, addr);
      chk("R6 busy", busy, k < T_DBG1);
      chk("R6 done", done, k >= T_DBG1);
      chk(k >= T_RST1 ? "R6 rst" : "R3 rst", rstc,
          k >= T_RST1 ? 2'b11 : (k >= 1 ? 2'b00 : p_rst));
      chk("R3 l1", l1, k >= 2 ? 1'b0 : p_l1);
      chk(k >= T_DBG1 ? "R6 dbg" : "R3 dbg", dbg,
          k >= T_DBG1 ? 1'b1 : (k >= 3 ? 1'b0 : p_dbg));
      chk("R4 clamp", clamp, up_clamp(k));
      chk("R5 gate", gate, k >= T_GATE ? 1'b0 : p_gate);
      if (k + 1 <= T_DBG1 && (($urandom % 4) == 0 || (hit_last && k + 1 == T_DBG1))) begin
        start = 1'b1; pdown = 1'($urandom % 2); entry = $urandom; injected = 1;
      end else begin
        start = 1'b0; pdown = 1'b0;
      end
    end
    start = 1'b0; pdown = 1'b0;
    p_boot = addr; p_rst = 2'b11; p_l1 = 1'b0; p_dbg = 1'b1;
    p_clamp = 8'h00; p_gate = 1'b0; p_done = 1'b1;
  endtask

  task automatic run_down(input bit with_start);
    string bt;
    bt = with_start ? "R11 boot" : "R9 boot";
    pdown = 1'b1; start = with_start; entry = ~p_boot;
    @(posedge clk);
    for (int k = 0; k <= T_DEND + 2; k++) begin
      @(negedge clk);
      chk(bt, boot, p_boot);
      chk("R9 busy", busy, k < T_DEND);
      chk("R9 done", done, 1'b0);
      chk("R9 dbg", dbg, k >= 1 ? 1'b0 : 1'b1);
      chk("R9 rst", rstc, k >= 2 ? 2'b00 : 2'b11);
      chk("R9 gate", gate, k >= 3 ? 1'b1 : 1'b0);
      chk("R9 l1", l1, 1'b0);
      chk("R9 clamp", clamp, dn_clamp(k));
      if (k + 1 <= T_DEND && ($urandom % 4) == 0) begin
        pdown = 1'b1; start = 1'b0;
      end else begin
        pdown = 1'b0; start = 1'b0;
      end
    end
    start = 1'b0; pdown = 1'b0;
    p_rst = 2'b00; p_dbg = 1'b0; p_clamp = 8'hFF; p_gate = 1'b1; p_done = 1'b0;
  endtask

  // idle cycles with ignored request pulses
  task automatic idle_hold(input int n, input bit use_start, input string tag);
    for (int i = 0; i < n; i++) begin
      start = use_start && ((i == 0) || ($urandom % 2 == 1));
      pdown = !use_start && ((i == 0) || ($urandom % 2 == 1));
      entry = $urandom;
      @(negedge clk);
      check_idle(tag);
    end
    start = 1'b0; pdown = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; pdown = 1'b0; entry = '0;
    p_boot = '0; p_rst = 2'b00; p_l1 = 1'b1; p_dbg = 1'b0;
    p_clamp = 8'hFF; p_gate = 1'b1; p_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after release");

    idle_hold(4, 1'b0, "R10");
    run_up(32'h8000_1000, 1'b1);
    idle_hold(6, 1'b1, "R8");
    run_down(1'b1);
    idle_hold(4, 1'b0, "R10");
    for (int r = 0; r < 3; r++) begin
      run_up($urandom, 1'b0);
      idle_hold(1 + int'($urandom % 4), 1'b1, "R8");
      run_down(1'b0);
    end
    run_up(32'hFFFF_FFFC, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R6 watchdog: actual busy=%0b expected sequence end", busy);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule